// File: doc/BRIEF.md
# Atomic Wide-Parameter Update Sequencer

Some control parameters are wider than one byte register and sit across a run of consecutive byte addresses. If each byte reached the live parameter as soon as it was written, logic downstream would, between writes, see a word whose upper bits are new while its lower bits are still old. This block sits beside the register file and watches the stream of write events. It holds the early bytes of a group in shadow registers and moves the whole parameter into the live register in one step, when the last byte of the group arrives.

The block also enforces the write discipline that makes this safe. A group must be written from its lowest address upward, with no write to any other address in between. When a sequence is broken, the block discards what it has staged, keeps the live value and raises a sticky error flag. Idle cycles without a write strobe may fall between the bytes of a group.

Top module: `atomic_param_seq`

## Requirements
- R1: The group occupies addresses BASE_ADDR to BASE_ADDR+NUM_BYTES-1. The byte at BASE_ADDR carries the most significant bits, and the last address carries bits [7:0]. With the defaults (base 0x34, two bytes, 11 bits), bits [2:0] of the byte at 0x34 become parameter bits [10:8], and its bits [7:3] are ignored.
- R2: While a group is partly written, `param_value` keeps its previous committed value.
- R3: A write to the last address that completes an ascending, uninterrupted group loads all bytes of the group into `param_value`, visible from the clock edge that samples that write.
- R4: `param_update` is high for exactly the one cycle in which a newly committed value first appears, and it is low otherwise.
- R5: A write to an address outside the group while a group is open discards the staged bytes, keeps `param_value`, and sets `seq_error`. A later write to the last address then commits nothing.
- R6: A write to a group address other than the first one that does not follow its predecessor in the open group commits nothing and sets `seq_error`. This includes writing the last address without a preceding write to the first.
- R7: A write to the first address while a group is already open sets `seq_error`, discards the old staged bytes, and opens a new group that holds the new byte.
- R8: Once set, `seq_error` stays high until reset.
- R9: A write outside the group while no group is open has no effect on any output.
- R10: Synchronous active-high reset sets `param_value` to RESET_VALUE, clears `seq_error` and `param_update`, and leaves no group open.
- R11: Cycles without a write strobe between the bytes of a group do not break the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Register address of the write |
| wr_data | input | 8 | Byte written |
| param_value | output | PARAM_W | Committed parameter value |
| param_update | output | 1 | One-cycle pulse on each commit |
| seq_error | output | 1 | Sticky write-sequence violation flag |

## Verification
The bench commits every one of the 2048 values of the default 11-bit parameter. It puts junk in the unused upper bits of the first byte and varies idle gaps and stray outside writes. A design that leaked a staged byte early would show mixed values between the two writes, and one that decoded the wrong bits of the high byte would be off on most of the sweep. Separate scenarios open a group and break it: with a foreign write, with a lone last-byte write, and with a repeated first-byte write. These expose a design that commits stale staged data, keeps a discarded byte, or lets the error flag fall back to low.

// File: rtl/aps_pkg.sv
package aps_pkg;
  localparam int BYTE_W = 8;

  // what a single write event does to the open group
  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_STAGE  = 2'd1,
    ACT_COMMIT = 2'd2,
    ACT_FAULT  = 2'd3
  } act_e;
endpackage

// File: rtl/aps_decode.sv
module aps_decode #(
  parameter int              ADDR_W    = 8,
  parameter int              NUM_BYTES = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h34,
  localparam int             IDX_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_BYTES);

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = wr_addr - BASE_ADDR;
    hit    = (wr_addr >= BASE_ADDR) && (offset < SPAN);
    idx    = offset[IDX_W-1:0];
  end
endmodule

// File: rtl/aps_tracker.sv
module aps_tracker
  import aps_pkg::*;
#(
  parameter int NUM_BYTES = 2,
  localparam int IDX_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             hit,
  input  logic [IDX_W-1:0] idx,
  output act_e             act,
  output logic             fault,
  output logic             pending
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES - 1);

  logic [IDX_W-1:0] expect_q, expect_d;
  logic             open_q, open_d;

  always_comb begin
    act      = ACT_NONE;
    fault    = 1'b0;
    open_d   = open_q;
    expect_d = expect_q;
    if (wr_en) begin
      if (hit && idx == '0) begin
        // start (or restart) a group
        act      = ACT_STAGE;
        fault    = open_q;
        open_d   = 1'b1;
        expect_d = IDX_W'(1);
      end else if (hit && open_q && idx == expect_q) begin
        if (idx == LAST_IDX) begin
          act    = ACT_COMMIT;
          open_d = 1'b0;
        end else begin
          act      = ACT_STAGE;
          expect_d = expect_q + IDX_W'(1);
        end
      end else if (hit || open_q) begin
        act    = ACT_FAULT;
        fault  = 1'b1;
        open_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q   <= 1'b0;
      expect_q <= '0;
    end else begin
      open_q   <= open_d;
      expect_q <= expect_d;
    end
  end

  assign pending = open_q;
endmodule

// File: rtl/aps_shadow.sv
module aps_shadow
  import aps_pkg::*;
#(
  parameter int NUM_BYTES = 2,
  localparam int IDX_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
  localparam int WORD_W   = NUM_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stage_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [WORD_W-1:0] word
);
  // shadow lanes for every byte but the last; the last comes from the bus
  for (genvar g = 0; g < NUM_BYTES - 1; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        lane_q <= '0;
      end else if (stage_en && idx == IDX_W'(g)) begin
        lane_q <= wr_data;
      end
    end
    assign word[(NUM_BYTES-1-g)*BYTE_W +: BYTE_W] = lane_q;
  end

  assign word[BYTE_W-1:0] = wr_data;
endmodule

// File: rtl/aps_commit.sv
module aps_commit #(
  parameter int               PARAM_W     = 11,
  parameter int               WORD_W      = 16,
  parameter logic [PARAM_W-1:0] RESET_VALUE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_en,
  input  logic              fault,
  input  logic [WORD_W-1:0] word,
  output logic [PARAM_W-1:0] param_value,
  output logic              param_update,
  output logic              seq_error
);
  if (WORD_W > PARAM_W) begin : g_spare
    logic unused_hi;
    assign unused_hi = ^word[WORD_W-1:PARAM_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      param_value  <= RESET_VALUE;
      param_update <= 1'b0;
      seq_error    <= 1'b0;
    end else begin
      param_update <= commit_en;
      if (commit_en) param_value <= word[PARAM_W-1:0];
      if (fault)     seq_error   <= 1'b1;
    end
  end
endmodule

// File: rtl/atomic_param_seq.sv
module atomic_param_seq
  import aps_pkg::*;
#(
  parameter int                 ADDR_W      = 8,
  parameter int                 NUM_BYTES   = 2,
  parameter int                 PARAM_W     = 11,
  parameter logic [ADDR_W-1:0]  BASE_ADDR   = 8'h34,
  parameter logic [PARAM_W-1:0] RESET_VALUE = 11'h155
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [7:0]         wr_data,
  output logic [PARAM_W-1:0] param_value,
  output logic               param_update,
  output logic               seq_error
);
  localparam int IDX_W  = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam int WORD_W = NUM_BYTES * BYTE_W;

  logic              hit;
  logic [IDX_W-1:0]  idx;
  act_e              act;
  logic              fault;
  logic              pending;
  logic [WORD_W-1:0] word;

  aps_decode #(
    .ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .BASE_ADDR(BASE_ADDR)
  ) u_decode (
    .wr_addr(wr_addr), .hit(hit), .idx(idx)
  );

  aps_tracker #(.NUM_BYTES(NUM_BYTES)) u_tracker (
    .clk(clk), .rst(rst), .wr_en(wr_en), .hit(hit), .idx(idx),
    .act(act), .fault(fault), .pending(pending)
  );

  aps_shadow #(.NUM_BYTES(NUM_BYTES)) u_shadow (
    .clk(clk), .rst(rst), .stage_en(act == ACT_STAGE), .idx(idx),
    .wr_data(wr_data), .word(word)
  );

  aps_commit #(
    .PARAM_W(PARAM_W), .WORD_W(WORD_W), .RESET_VALUE(RESET_VALUE)
  ) u_commit (
    .clk(clk), .rst(rst), .commit_en(act == ACT_COMMIT), .fault(fault),
    .word(word), .param_value(param_value), .param_update(param_update),
    .seq_error(seq_error)
  );
endmodule

// File: rtl/aps_checker.sv
module aps_checker #(
  parameter int                 ADDR_W      = 8,
  parameter int                 NUM_BYTES   = 2,
  parameter int                 PARAM_W     = 11,
  parameter logic [ADDR_W-1:0]  BASE_ADDR   = 8'h34,
  parameter logic [PARAM_W-1:0] RESET_VALUE = 11'h155
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [PARAM_W-1:0] param_value,
  input logic               param_update,
  input logic               seq_error,
  input logic               pending
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = BASE_ADDR + ADDR_W'(NUM_BYTES - 1);

  logic outside;
  assign outside = (wr_addr < BASE_ADDR) || (wr_addr > LAST_ADDR);

  assert_hold_while_open_R2: assert property (@(posedge clk) disable iff (rst)
    !param_update |-> $stable(param_value));

  assert_commit_from_last_R3: assert property (@(posedge clk) disable iff (rst)
    param_update |-> $past(wr_en && wr_addr == LAST_ADDR));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    param_update |=> !param_update);

  assert_no_pulse_open_R4: assert property (@(posedge clk) disable iff (rst)
    pending |-> !param_update);

  assert_break_flags_R5: assert property (@(posedge clk) disable iff (rst)
    (pending && wr_en && outside) |=> (seq_error && !pending));

  assert_sticky_error_R8: assert property (@(posedge clk) disable iff (rst)
    seq_error |=> seq_error);

  assert_idle_outside_R9: assert property (@(posedge clk) disable iff (rst)
    (!pending && wr_en && outside) |=> (!param_update && $stable(seq_error)));

  assert_reset_state_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (param_value == RESET_VALUE && !seq_error && !param_update && !pending));
endmodule

bind atomic_param_seq aps_checker #(
  .ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .PARAM_W(PARAM_W),
  .BASE_ADDR(BASE_ADDR), .RESET_VALUE(RESET_VALUE)
) u_aps_checker (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .param_value(param_value), .param_update(param_update),
  .seq_error(seq_error), .pending(pending)
);

// File: tb/test_atomic_param_seq.sv
`timescale 1ns/1ps
module test_atomic_param_seq;
  localparam logic [7:0]  BASE = 8'h34;
  localparam logic [10:0] RSTV = 11'h155;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [10:0] param_value;
  logic        param_update;
  logic        seq_error;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [10:0] live;

  always #2.5 clk = ~clk;

  atomic_param_seq i_atomic_param_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .param_value(param_value), .param_update(param_update), .seq_error(seq_error)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the sampling edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    live = RSTV;
    chk(param_value == RSTV, "R10 value", int'(param_value), int'(RSTV));
    chk(!seq_error && !param_update, "R10 flags", int'({seq_error, param_update}), 0);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    live = RSTV;
    do_reset();

    // R10: nothing open after reset, so a lone last byte commits nothing
    wr(BASE + 8'd1, 8'hEE);
    chk(param_value == RSTV && !param_update, "R10 no open group", int'(param_value), int'(RSTV));
    chk(seq_error, "R6 lone last byte", int'(seq_error), 1);
    do_reset();

    // R1 R2 R3 R4 R9 R11: sweep every 11-bit value
    for (int v = 0; v < 2048; v++) begin
      logic [7:0] hi, lo;
      hi = 8'(((v >> 8) & 7) | ((v * 5) << 3));
      lo = 8'(v & 255);
      if (v % 7 == 3) begin
        wr(8'h10 + 8'(v % 32), 8'(v));
        chk(param_value == live && !param_update && !seq_error, "R9 idle foreign write",
            int'(param_value), int'(live));
      end
      wr(BASE, hi);
      chk(param_value == live && !param_update, "R2 hold after first byte",
          int'(param_value), int'(live));
      if (v % 2 == 1) begin
        @(negedge clk); @(negedge clk);
        chk(param_value == live, "R11 gap hold", int'(param_value), int'(live));
      end
      wr(BASE + 8'd1, lo);
      live = 11'(v);
      chk(param_value == live, "R1 R3 committed value", int'(param_value), v);
      chk(param_update, "R4 pulse on commit", int'(param_update), 1);
      @(negedge clk);
      chk(!param_update, "R4 pulse ends", int'(param_update), 0);
    end
    chk(!seq_error, "R11 no error in sweep", int'(seq_error), 0);

    // R5: foreign write breaks an open group
    wr(BASE, 8'h07);
    wr(8'h50, 8'h11);
    chk(seq_error && param_value == live, "R5 break flags", int'(param_value), int'(live));
    wr(BASE + 8'd1, 8'hAA);
    chk(param_value == live && !param_update, "R5 staged discarded", int'(param_value), int'(live));

    // R8: error stays through a good group
    wr(BASE, 8'h02);
    wr(BASE + 8'd1, 8'h22);
    live = 11'h222;
    chk(param_value == live, "R8 commit after error", int'(param_value), int'(live));
    repeat (5) @(negedge clk);
    chk(seq_error, "R8 sticky", int'(seq_error), 1);

    // R7: repeated first byte restarts with new data
    do_reset();
    wr(BASE, 8'h01);
    wr(BASE, 8'h05);
    chk(seq_error && param_value == RSTV, "R7 restart flags", int'(seq_error), 1);
    wr(BASE + 8'd1, 8'h33);
    chk(param_value == 11'h533 && param_update, "R7 new byte kept", int'(param_value), 'h533);

    // R6 after a clean commit: a second last-byte write is out of order
    do_reset();
    wr(BASE, 8'h03);
    wr(BASE + 8'd1, 8'h44);
    chk(param_value == 11'h344, "R3 clean commit", int'(param_value), 'h344);
    wr(BASE + 8'd1, 8'h99);
    chk(param_value == 11'h344 && !param_update && seq_error, "R6 repeated last byte",
        int'(param_value), 'h344);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule